// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is one DMA channel. It holds a source address, a destination address and a transfer count, and it moves one unit of data for each request it accepts. A request arrives as a pulse from an external trigger selector and sets a pending flag. When the channel is enabled and a request is pending, the sequencer runs a read phase on a simple bus master handshake, then a write phase, and returns to idle.

After each transfer the source and destination addresses each either stay where they are or advance by the transfer size. The size is a byte or a 16-bit word. The count is then decremented. When the count runs out, the channel behaves in one of two ways. In single mode it turns itself off. In repeat mode it restores the addresses and the count from copies saved at programming time, and it keeps running.

Software programs the channel through a byte-wide register port. Each address and count write goes both to the working register and to its reload copy.

Top module: `dma_chan_seq`

## Requirements
- R1: Register map at `cfg_addr`: 0 control; 1/2 source address low/high byte; 3/4 destination address low/high byte; 5/6 count low/high byte; 7 status. Addresses and count read back their working values. After reset every register reads 0 and both `bus_rd` and `bus_wr` are low.
- R2: Control bits 7 and 6 always read 0, and writing 1 to them has no effect.
- R3: Control bit 2 is the request-pending flag. A `req` pulse sets it. Software writing 0 to it clears it, and software writing 1 leaves it unchanged. The flag clears when a transfer starts.
- R4: With enable (control bit 3) at 1 and a request pending, the block does a read phase and then a write phase. In the read phase `bus_rd` is high with `bus_addr` at the source address, and both hold until `bus_ready`. In the write phase `bus_wr` is high with `bus_addr` at the destination address and `bus_wdata` equal to the data read, and these hold until `bus_ready`. `bus_rd` and `bus_wr` are never high together. While enable is 0, no bus phase starts and the request stays pending.
- R5: Control bit 0 selects the unit: 0 means a 16-bit word (`bus_byte` low, forward step 2), and 1 means a byte (`bus_byte` high, forward step 1).
- R6: Control bit 4 (source) and bit 5 (destination) each select fixed (0) or forward (1). A forward address advances by the step after each transfer, and a fixed address does not change.
- R7: Writing control with bits 5 and 4 both at 1 stores bit 5 as 0, so the destination is fixed, and sets status bit 0 and `dir_err`. A later control write that is legal clears them.
- R8: Each completed transfer decrements the count by 1.
- R9: Control bit 1 at 0 (single mode): the transfer that brings the count to 0 clears enable, and later requests cause no bus activity.
- R10: Control bit 1 at 1 (repeat mode): at that same point the addresses and the count reload from their programmed values, and enable stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| req | input | 1 | Transfer request pulse from the trigger selector |
| bus_rd | output | 1 | Read phase active |
| bus_wr | output | 1 | Write phase active |
| bus_byte | output | 1 | Transfer is one byte (else a 16-bit word) |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Current phase completes this cycle |
| dir_err | output | 1 | Illegal direction setting was corrected |

## Verification
The assertions check the handshake rules on every cycle. Read and write never overlap, and address and data hold while ready is low. They also check that an illegal direction write is corrected, that a fixed source stays put, that the count steps down by one, and how enable and the reload behave at terminal count.

Only the bench scenarios can show the full address sequence for each mix of unit, mode and direction bits. The same goes for the data carried from read to write, the request flag's response to software, and the silence of a single-mode channel after it stops. The bench sweeps all sixteen combinations of the four configuration bits.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  input  logic              bus_ready,
  output logic              dir_err
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;
  state_t state;

  logic unit, rpt, pend, en, sfwd, dfwd, err;
  logic [ADDR_W-1:0] src, dst, src_rl, dst_rl;
  logic [CNT_W-1:0]  cnt, cnt_rl;
  logic [15:0]       data;

  wire ctl_wr = cfg_we && cfg_addr == 3'd0;
  wire reg_wr = cfg_we && cfg_addr != 3'd0 && cfg_addr != 3'd7;
  wire start  = state == S_IDLE && en && pend;
  wire done   = state == S_WRITE && bus_ready;
  wire last   = cnt <= CNT_W'(1);
  wire [ADDR_W-1:0] step = unit ? ADDR_W'(1) : ADDR_W'(2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= S_IDLE;
    else case (state)
      S_IDLE:  if (start) state <= S_READ;
      S_READ:  if (bus_ready) state <= S_WRITE;
      S_WRITE: if (bus_ready) state <= S_IDLE;
      default: state <= S_IDLE;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= 1'b0;
    else if (req) pend <= 1'b1;
    else if (start || (ctl_wr && !cfg_wdata[2])) pend <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      unit <= 1'b0; rpt <= 1'b0; en <= 1'b0;
      sfwd <= 1'b0; dfwd <= 1'b0; err <= 1'b0;
    end else if (ctl_wr) begin
      unit <= cfg_wdata[0];
      rpt  <= cfg_wdata[1];
      en   <= cfg_wdata[3];
      sfwd <= cfg_wdata[4];
      dfwd <= cfg_wdata[5] & ~cfg_wdata[4];
      err  <= cfg_wdata[5] & cfg_wdata[4];
    end else if (done && last && !rpt) begin
      en <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) data <= '0;
    else if (state == S_READ && bus_ready) data <= bus_rdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src <= '0; dst <= '0; cnt <= '0;
      src_rl <= '0; dst_rl <= '0; cnt_rl <= '0;
    end else if (reg_wr) begin
      case (cfg_addr)
        3'd1: begin src[7:0] <= cfg_wdata; src_rl[7:0] <= cfg_wdata; end
        3'd2: begin src[ADDR_W-1:8] <= cfg_wdata[ADDR_W-9:0]; src_rl[ADDR_W-1:8] <= cfg_wdata[ADDR_W-9:0]; end
        3'd3: begin dst[7:0] <= cfg_wdata; dst_rl[7:0] <= cfg_wdata; end
        3'd4: begin dst[ADDR_W-1:8] <= cfg_wdata[ADDR_W-9:0]; dst_rl[ADDR_W-1:8] <= cfg_wdata[ADDR_W-9:0]; end
        3'd5: begin cnt[7:0] <= cfg_wdata; cnt_rl[7:0] <= cfg_wdata; end
        3'd6: begin cnt[CNT_W-1:8] <= cfg_wdata[CNT_W-9:0]; cnt_rl[CNT_W-1:8] <= cfg_wdata[CNT_W-9:0]; end
        default: ;
      endcase
    end else if (done) begin
      if (last && rpt) begin
        src <= src_rl; dst <= dst_rl; cnt <= cnt_rl;
      end else begin
        if (sfwd) src <= src + step;
        if (dfwd) dst <= dst + step;
        cnt <= last ? '0 : cnt - CNT_W'(1);
      end
    end

  assign bus_rd    = state == S_READ;
  assign bus_wr    = state == S_WRITE;
  assign bus_addr  = bus_wr ? dst : src;
  assign bus_byte  = unit;
  assign bus_wdata = data;
  assign dir_err   = err;

  always_comb
    case (cfg_addr)
      3'd0: cfg_rdata = {2'b00, dfwd, sfwd, en, pend, rpt, unit};
      3'd1: cfg_rdata = src[7:0];
      3'd2: cfg_rdata = 8'(src[ADDR_W-1:8]);
      3'd3: cfg_rdata = dst[7:0];
      3'd4: cfg_rdata = 8'(dst[ADDR_W-1:8]);
      3'd5: cfg_rdata = cnt[7:0];
      3'd6: cfg_rdata = 8'(cnt[CNT_W-1:8]);
      default: cfg_rdata = {7'b0, err};
    endcase

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_ready |=> bus_rd && $stable(bus_addr)); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_ready && !cfg_we |=> bus_wr && $stable(bus_addr) && $stable(bus_wdata)); // R4
  AST_DIR_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 3'd0 && cfg_wdata[5:4] == 2'b11 |=> dir_err && cfg_rdata[5] == 1'b0 || cfg_addr != 3'd0 && dir_err); // R7
  AST_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    done && !sfwd && !(last && rpt) && !cfg_we |=> $stable(src)); // R6
  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    done && !last && !cfg_we |=> cnt == $past(cnt) - CNT_W'(1)); // R8
  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done && last && !rpt && !cfg_we |=> !en && !bus_rd); // R9
  AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done && last && rpt && !cfg_we |=> en && cnt == cnt_rl && src == src_rl && dst == dst_rl); // R10

endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, req = 1'b0, bus_ready = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [7:0] cfg_wdata = 8'h00, cfg_rdata;
  logic bus_rd, bus_wr, bus_byte, dir_err;
  logic [15:0] bus_addr, bus_wdata, bus_rdata = 16'h0;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  dma_chan_seq u_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .dir_err(dir_err));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); d = {hi, lo};
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]); wr(a + 3'd1, d[15:8]);
  endtask

  task automatic pulse_req;
    @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
  endtask

  task automatic xfer(input logic [15:0] es, input logic [15:0] ed, input logic eb, input int w);
    int n;
    pulse_req();
    n = 0;
    while (!bus_rd && n < 10) begin @(negedge clk); n++; end
    chk("R4 read phase", bus_rd, 1);
    chk("R4 no overlap", bus_wr, 0);
    chk("R6 source address", bus_addr, es);
    chk("R5 unit", bus_byte, eb);
    repeat (w) begin @(negedge clk); chk("R4 read hold", {bus_rd, bus_addr}, {1'b1, es}); end
    bus_ready = 1'b1; bus_rdata = es ^ 16'h5A3C;
    @(negedge clk); bus_ready = 1'b0;
    n = 0;
    while (!bus_wr && n < 10) begin @(negedge clk); n++; end
    chk("R4 write phase", {bus_rd, bus_wr}, 2'b01);
    chk("R6 destination address", bus_addr, ed);
    chk("R4 write data", bus_wdata, es ^ 16'h5A3C);
    repeat (w) begin @(negedge clk); chk("R4 write hold", {bus_wr, bus_addr}, {1'b1, ed}); end
    bus_ready = 1'b1;
    @(negedge clk); bus_ready = 1'b0;
  endtask

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin rd(3'(a), b); chk("R1 reset value", b, 0); end
    chk("R1 bus idle", {bus_rd, bus_wr}, 0);

    wr(0, 8'hC0); rd(0, b); chk("R2 upper bits", b, 8'h00);
    wr(0, 8'h04); rd(0, b); chk("R3 write 1 ignored", b[2], 0);
    pulse_req(); @(negedge clk); rd(0, b); chk("R3 set by req", b[2], 1);
    repeat (4) begin @(negedge clk); chk("R4 disabled no bus", bus_rd | bus_wr, 0); end
    wr(0, 8'h00); rd(0, b); chk("R3 write 0 clears", b[2], 0);

    for (int c = 0; c < 16; c++) begin
      logic unit, mode, sf, df, dfe;
      logic [15:0] s0, d0, stp, es, ed;
      unit = c[0]; mode = c[1]; sf = c[2]; df = c[3];
      dfe = df & ~sf;
      stp = unit ? 16'd1 : 16'd2;
      s0 = 16'h1200 + 16'(c * 16'h40);
      d0 = 16'h8A00 - 16'(c * 16'h20);
      wr(0, 8'h00);
      wr16(1, s0); wr16(3, d0); wr16(5, 16'd3);
      wr(0, {2'b00, df, sf, 1'b1, 1'b0, mode, unit});
      rd(0, b); chk("R7 control readback", b, {2'b00, dfe, sf, 1'b1, 1'b0, mode, unit});
      rd(7, b); chk("R7 status flag", b, {7'b0, sf & df});
      chk("R7 error port", dir_err, sf & df);
      for (int k = 0; k < 3; k++) begin
        es = s0 + (sf ? 16'(k) * stp : 16'd0);
        ed = d0 + (dfe ? 16'(k) * stp : 16'd0);
        xfer(es, ed, unit, (c + k) % 3);
        if (k == 0) begin rd16(5, v); chk("R8 count decrement", v, 2); end
      end
      rd(0, b);
      rd16(1, es); rd16(3, ed); rd16(5, v);
      if (!mode) begin
        chk("R9 enable cleared", b[3], 0);
        chk("R6 final source", es, s0 + (sf ? 16'd3 * stp : 16'd0));
        chk("R6 final destination", ed, d0 + (dfe ? 16'd3 * stp : 16'd0));
        chk("R8 count zero", v, 0);
        pulse_req();
        repeat (6) begin @(negedge clk); chk("R9 stopped", bus_rd | bus_wr, 0); end
      end else begin
        chk("R10 enable kept", b[3], 1);
        chk("R10 source reload", es, s0);
        chk("R10 destination reload", ed, d0);
        chk("R10 count reload", v, 3);
        xfer(s0, d0, unit, 1);
      end
    end
    wr(0, 8'h10); rd(7, b); chk("R7 flag cleared by legal write", b, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule